// File: doc/BRIEF.md
# Five-Bank LED Multiplex Scanner

This block time-multiplexes five common-cathode LED banks. A prescaler divides the system clock into bank slots. Each slot closes one bank switch, and while that switch is closed the block puts that bank's eight segment bits on the shared anode lines. The segment words come from a display register held elsewhere. Every slot begins with one system clock in which all banks and all anodes are off, so the segment pattern of one bank never lights on the next bank.

Two controls override the scan. A low-power flag stops the scan and holds every output inactive. A load-blanking pulse, issued whenever the display or configuration register is written, darkens the display for one slot and then restarts the scan at bank 1. Reset puts the block in its low-power state, so the display comes up dark.

The state machine has four states. ST_SLEEP: everything off, scan frozen. ST_BLANK: load blanking, everything off. ST_GAP: the single dark clock that opens each slot. ST_DRIVE: one bank lit. Its transitions are as follows. Any state goes to ST_SLEEP while low power is set, and otherwise goes to ST_BLANK when a load arrives. ST_SLEEP goes to ST_GAP for bank 1 once low power is clear. ST_BLANK goes to ST_GAP for bank 1 when its slot ends. ST_GAP always goes to ST_DRIVE. ST_DRIVE goes to ST_GAP for the next bank at the end of the slot, and bank 5 wraps to bank 1.

Top module: `led_bank_scanner`

## Requirements
- R1: One slot lasts STEP_DIV clocks. The banks are lit in the order 1, 2, 3, 4, 5 and then repeat, so a frame lasts 5*STEP_DIV clocks. Each bank is lit for STEP_DIV-1 clocks per frame, an equal one-fifth share. The default of 40000 at a 200 MHz clock gives a 1 ms frame.
- R2: `bank_n_o` is active-low, with bit 0 for bank 1, and never more than one of its bits is low. `anode_o` is active-high. While bank k is lit, `anode_o` equals byte k-1 of `seg_words_i` (bits 8(k-1) to 8(k-1)+7), with anode bit 0 = segment a through bit 6 = segment g and bit 7 = the decimal point.
- R3: The first clock of every slot is dark, with all of `bank_n_o` high and `anode_o` zero. A closed bank switch is therefore never replaced directly by a different one.
- R4: If `low_power_i` is high at a clock edge, every output is inactive from the next clock on and stays so while the flag stays high. After the flag is released, the first clock is dark and the next STEP_DIV-1 clocks light bank 1.
- R5: If `load_blank_i` is high at an edge and low power is clear, the next STEP_DIV clocks are dark. One dark gap clock follows, and then bank 1 is lit. A new load during blanking restarts the interval.
- R6: While reset is asserted, and after it is released while low power is still set, `bank_n_o` is 5'b11111 and `anode_o` is 8'h00.
- R7: Low power takes priority over a load. A load that coincides with low power does not end the dark state after one slot.
- R8: `anode_o` is zero whenever no bank is lit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_power_i | input | 1 | Freeze the scan and darken all outputs |
| load_blank_i | input | 1 | Register-load pulse; starts a one-slot blanking interval |
| seg_words_i | input | 40 | Five segment bytes; byte 0 belongs to bank 1 |
| bank_n_o | output | 5 | Active-low bank switch enables, bit 0 = bank 1 |
| anode_o | output | 8 | Active-high anode drives, a..g in bits 0..6, h in bit 7 |

## Verification
The outputs are decoded combinationally from the state register, so a control seen at a clock edge shows at the ports in the clock that follows that edge. Changes to the segment words show in the same clock. The bench drives inputs on the falling edge and samples once per clock on the next falling edge. From the clock that follows each restart event (low-power release or a load), it keeps a position count and predicts every clock: STEP_DIV dark clocks after a load, then a repeating slot of one dark clock followed by STEP_DIV-1 lit clocks. Per-bank lit counts over whole frames check the equal share.

// File: rtl/scan_pkg.sv
package scan_pkg;
    localparam int NUM_BANKS = 5;
    localparam int SEG_W     = 8;

    typedef enum logic [1:0] {
        ST_SLEEP,
        ST_BLANK,
        ST_GAP,
        ST_DRIVE
    } scan_state_t;
endpackage

// File: rtl/scan_prescaler.sv
module scan_prescaler #(
    parameter int DIV = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic tick_o
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clear_i)        cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + CNT_W'(1);
    end

    assign tick_o = (cnt_q == LAST) && !clear_i;

    // R1: the slot counter never leaves its range
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
#(
    parameter int BANKS = NUM_BANKS,
    parameter int IDX_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_power_i,
    input  logic              load_blank_i,
    input  logic              tick_i,
    output scan_state_t       state_o,
    output logic [IDX_W-1:0]  idx_o
);
    scan_state_t      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SLEEP;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (low_power_i) begin
            state_d = ST_SLEEP;
            idx_d   = '0;
        end else if (load_blank_i) begin
            state_d = ST_BLANK;
            idx_d   = '0;
        end else begin
            unique case (state_q)
                ST_SLEEP: begin
                    state_d = ST_GAP;
                    idx_d   = '0;
                end
                ST_BLANK: if (tick_i) begin
                    state_d = ST_GAP;
                    idx_d   = '0;
                end
                ST_GAP:   state_d = ST_DRIVE;
                ST_DRIVE: if (tick_i) begin
                    state_d = ST_GAP;
                    idx_d   = (idx_q == IDX_W'(BANKS - 1)) ? '0 : idx_q + IDX_W'(1);
                end
                default:  state_d = ST_SLEEP;
            endcase
        end
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;

    // R3: a lit bank is always entered through the dark gap clock
    p_gap_before_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE && $past(state_q) != ST_DRIVE) |-> $past(state_q) == ST_GAP);
    // R5: leaving load blanking resumes at bank 1
    p_blank_to_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && $past(state_q) == ST_BLANK) |-> idx_q == '0);
endmodule

// File: rtl/scan_drive.sv
module scan_drive
    import scan_pkg::*;
#(
    parameter int BANKS = NUM_BANKS,
    parameter int SW    = SEG_W,
    parameter int IDX_W = $clog2(BANKS)
) (
    input  scan_state_t        state_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [BANKS*SW-1:0] seg_words_i,
    output logic [BANKS-1:0]   bank_n_o,
    output logic [SW-1:0]      anode_o
);
    always_comb begin
        bank_n_o = '1;
        anode_o  = '0;
        if (state_i == ST_DRIVE) begin
            for (int b = 0; b < BANKS; b++) begin
                if (idx_i == IDX_W'(b)) begin
                    bank_n_o[b] = 1'b0;
                    anode_o     = seg_words_i[b*SW +: SW];
                end
            end
        end
    end
endmodule

// File: rtl/led_bank_scanner.sv
module led_bank_scanner
    import scan_pkg::*;
#(
    parameter int BANKS    = NUM_BANKS,
    parameter int SW       = SEG_W,
    parameter int STEP_DIV = 40000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  low_power_i,
    input  logic                  load_blank_i,
    input  logic [BANKS*SW-1:0]   seg_words_i,
    output logic [BANKS-1:0]      bank_n_o,
    output logic [SW-1:0]         anode_o
);
    localparam int IDX_W = $clog2(BANKS);

    scan_state_t      state;
    logic [IDX_W-1:0] idx;
    logic             tick;
    logic             pre_clear;

    assign pre_clear = low_power_i || load_blank_i || (state == ST_SLEEP);

    scan_prescaler #(.DIV(STEP_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (pre_clear),
        .tick_o  (tick)
    );

    scan_fsm #(.BANKS(BANKS), .IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .low_power_i  (low_power_i),
        .load_blank_i (load_blank_i),
        .tick_i       (tick),
        .state_o      (state),
        .idx_o        (idx)
    );

    scan_drive #(.BANKS(BANKS), .SW(SW), .IDX_W(IDX_W)) u_drv (
        .state_i     (state),
        .idx_i       (idx),
        .seg_words_i (seg_words_i),
        .bank_n_o    (bank_n_o),
        .anode_o     (anode_o)
    );

    // R2: never more than one bank switch closed
    p_bank_onecold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bank_n_o));
    // R8: anodes dark whenever no bank is closed
    p_dark_anodes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_n_o == '1) |-> (anode_o == '0));
    // R3: one closed bank is never replaced directly by another
    p_switch_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_n_o != '1 && $past(bank_n_o) != '1) |-> bank_n_o == $past(bank_n_o));
    // R4: low power darkens the display on the next clock
    p_lowpower_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(low_power_i) |-> (bank_n_o == '1 && anode_o == '0));
    // R5: a load darkens the display on the next clock
    p_load_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_blank_i) |-> bank_n_o == '1);
endmodule

// File: tb/led_bank_scanner_test.sv
`timescale 1ns/1ps
module led_bank_scanner_test;
    localparam int DIV = 6;
    localparam int NB  = 5;
    localparam int FR  = 2;
    localparam logic [39:0] PATS [3] = '{
        40'h8F_4C_21_7E_03,
        40'h01_02_04_08_10,
        40'hFF_A5_5A_C3_3C
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        low_power = 1'b1;
    logic        load_blank = 1'b0;
    logic [39:0] segs = '0;
    logic [4:0]  bank_n;
    logic [7:0]  anode;

    int checks = 0;
    int failures = 0;
    int j = 0;
    int lead = 0;
    int lit [NB];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    led_bank_scanner #(.STEP_DIV(DIV)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .low_power_i  (low_power),
        .load_blank_i (load_blank),
        .seg_words_i  (segs),
        .bank_n_o     (bank_n),
        .anode_o      (anode)
    );

    task automatic expect_out(string req, logic [4:0] eb, logic [7:0] ea);
        checks++;
        if (bank_n !== eb || anode !== ea) begin
            failures++;
            $display("FAIL %s: bank_n=%b anode=%h expected bank_n=%b anode=%h",
                     req, bank_n, anode, eb, ea);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step_model(string req);
        int phase;
        int b;
        step();
        if (lead > 0) begin
            lead--;
            expect_out(req, 5'b11111, 8'h00);
        end else begin
            j++;
            phase = (j - 1) % DIV;
            b     = ((j - 1) / DIV) % NB;
            if (phase == 0) begin
                expect_out(req, 5'b11111, 8'h00);
            end else begin
                expect_out(req, 5'(~(5'd1 << b)), segs[b*8 +: 8]);
                if (bank_n == 5'(~(5'd1 << b))) lit[b]++;
            end
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        segs = PATS[0];
        repeat (3) @(negedge clk);
        expect_out("R6 during reset", 5'b11111, 8'h00);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            expect_out("R6 low power after reset", 5'b11111, 8'h00);
        end

        // release low power: scan starts with gap then bank 1 (R4, R1, R2, R3)
        low_power = 1'b0;
        j = 0;
        lead = 0;
        for (int r = 0; r < 3; r++) begin
            segs = PATS[r];
            for (int b = 0; b < NB; b++) lit[b] = 0;
            repeat (FR * NB * DIV) step_model("R1 R2 R3 scan order and anodes");
            for (int b = 0; b < NB; b++) begin
                checks++;
                if (lit[b] != FR * (DIV - 1)) begin
                    failures++;
                    $display("FAIL R1 share bank %0d: lit=%0d expected %0d",
                             b + 1, lit[b], FR * (DIV - 1));
                end
            end
        end

        // load blanking mid-frame (R5)
        repeat (2 * DIV + 3) step_model("R1 before load");
        load_blank = 1'b1;
        lead = DIV; j = 0;
        step_model("R5 load blank start");
        load_blank = 1'b0;
        repeat (2) step_model("R5 blanking");
        // reload during blanking restarts it
        load_blank = 1'b1;
        lead = DIV; j = 0;
        step_model("R5 reload restart");
        load_blank = 1'b0;
        repeat (DIV + 2 * DIV) step_model("R5 blank then bank 1");

        // low power freeze, with a load during it (R4, R7)
        low_power = 1'b1;
        for (int i = 0; i < 4 * DIV; i++) begin
            if (i == 5) load_blank = 1'b1;
            if (i == 7) load_blank = 1'b0;
            step();
            expect_out("R4 low power dark", 5'b11111, 8'h00);
        end
        low_power = 1'b0;
        j = 0; lead = 0;
        repeat (NB * DIV) step_model("R4 resume at bank 1");

        // simultaneous low power and load: low power wins (R7)
        low_power = 1'b1;
        load_blank = 1'b1;
        step();
        expect_out("R7 both asserted", 5'b11111, 8'h00);
        load_blank = 1'b0;
        for (int i = 0; i < 2 * DIV; i++) begin
            step();
            expect_out("R7 low power keeps dark", 5'b11111, 8'h00);
        end
        low_power = 1'b0;
        j = 0; lead = 0;
        repeat (NB * DIV) step_model("R7 resume after priority");

        // R8 through a dark gap with all segments set
        segs = 40'hFF_FF_FF_FF_FF;
        repeat (NB * DIV) step_model("R8 dark gap anodes zero");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule